// File: doc/BRIEF.md
# Enable-Framed Serial Control Word Receiver

This block receives 8-bit control words over a three-wire serial link: a bit clock, a data line and an active-low frame enable. It sits in the system-clock domain and oversamples all three wires, so the serial clock never clocks any flop directly. Each period during which the enable is low forms one frame. Bits are taken most significant first, one on each rising edge of the serial clock.

A frame becomes a write only when it ends correctly. At least a full word of bits must have arrived. The enable must then rise and stay high for a programmable number of system-clock cycles. When both hold, the captured word appears on `word_o` together with a strobe one cycle wide, which a downstream register bank consumes. A frame that is too short, or an enable-high gap that is too brief, leaves the output untouched. When a frame carries extra clocks, the bits after the first word are dropped. A select input turns the whole receiver on or off.

Top module: `ctl_word_rx`

## Requirements
- R1: While `sel_i` is low, the receiver accepts no bits and commits no word. `word_vld_o` stays low and `word_o` keeps its value.
- R2: Bits are sampled on rising edges of `sclk_i` and shifted in most significant first. The first bit of a frame lands in `word_o[7]` and the eighth in `word_o[0]`.
- R3: Serial clock edges that arrive while `en_n_i` is high are ignored. They produce no strobe and do not change `word_o`. Every falling edge of `en_n_i` starts a frame with an empty bit count.
- R4: A frame that ends with fewer than 8 bits is discarded: no strobe, and `word_o` is unchanged.
- R5: If more than 8 rising clock edges occur within one frame, only the first 8 bits are kept. The bit count saturates at 8.
- R6: A complete frame commits once `en_n_i` has been sampled high on MIN_HIGH consecutive system-clock edges (MIN_HIGH is 2 or more). `word_vld_o` is then high for exactly one cycle, no more than MIN_HIGH+2 cycles after the first high sample. `word_o` changes only together with the strobe and holds its value until the next commit.
- R7: If `en_n_i` is high for fewer than MIN_HIGH samples before it falls again, the frame is dropped. The following frame starts empty.
- R8: After a synchronous reset, `word_o` is 0 and `word_vld_o` is 0.
- R9: A new frame may begin while the previous word is still held on `word_o`. Two frames sent back to back each produce their own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Receiver select; high enables the interface |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial data, most significant bit first (asynchronous) |
| en_n_i | input | 1 | Frame enable, active low (asynchronous) |
| word_o | output | 8 | Last committed control word |
| word_vld_o | output | 1 | One-cycle strobe marking a newly committed word |

## Verification
Faults in the internal state appear as a strobe that should be missing or is missing when it should appear, or as a wrong word. They show up within MIN_HIGH+2 cycles after the enable rises. A bit count that fails to saturate or fails to clear surfaces as shifted or corrupted words in long frames, and as a spurious commit after a dropped frame. A broken high-time counter turns the one-sample boundary at MIN_HIGH into a visible commit or a visible absence of one. Stray bits accepted outside a frame would show as a word that differs from the transmitted byte.

// File: rtl/ctlrx_pkg.sv
package ctlrx_pkg;
  // bit positions inside the synchronized input vector
  localparam int SCLK_IX = 0;
  localparam int SDAT_IX = 1;
  localparam int EN_IX   = 2;
  localparam int N_WIRES = 3;

  typedef enum logic {
    CM_IDLE  = 1'b0,
    CM_ARMED = 1'b1
  } commit_st_t;
endpackage

// File: rtl/ctlrx_sync.sv
module ctlrx_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/ctlrx_edge.sv
module ctlrx_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/ctlrx_shift.sv
module ctlrx_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic              en_low_i,
  input  logic              start_i,
  input  logic              sclk_s_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;
  logic              sclk_prev_q;
  logic              sclk_rise;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev_q <= 1'b0;
    else     sclk_prev_q <= sclk_s_i;
  end
  assign sclk_rise = sclk_s_i & ~sclk_prev_q;

  assign full_o = (cnt_q == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (act_i) begin
      if (start_i) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (en_low_i && sclk_rise && !full_o) begin
        sh_q  <= {sh_q[WORD_W-2:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_o = sh_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL); // R5

  AST_KEEP_FIRST: assert property (@(posedge clk) disable iff (rst)
    (full_o && !start_i) |=> $stable(sh_q)); // R5

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!en_low_i) |=> ($stable(sh_q) && $stable(cnt_q))); // R3
endmodule

// File: rtl/ctlrx_commit.sv
module ctlrx_commit
  import ctlrx_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int MIN_HIGH = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic              en_hi_i,
  input  logic              en_rise_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);
  localparam int HW = $clog2(MIN_HIGH + 1);
  localparam logic [HW-1:0] HI_LAST = HW'(MIN_HIGH - 1);

  commit_st_t        st_q;
  logic [HW-1:0]     hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CM_IDLE;
      hi_q   <= '0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!act_i) begin
        st_q <= CM_IDLE;
      end else begin
        case (st_q)
          CM_IDLE: begin
            if (en_rise_i && full_i) begin
              st_q <= CM_ARMED;
              hi_q <= HW'(1);
            end
          end
          CM_ARMED: begin
            if (!en_hi_i) begin
              st_q <= CM_IDLE;
            end else if (hi_q >= HI_LAST) begin
              word_o <= word_i;
              vld_o  <= 1'b1;
              st_q   <= CM_IDLE;
            end else begin
              hi_q <= hi_q + 1'b1;
            end
          end
          default: st_q <= CM_IDLE;
        endcase
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o); // R6

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_o) |-> vld_o); // R6

  AST_SEL_OFF: assert property (@(posedge clk) disable iff (rst)
    !act_i |=> !vld_o); // R1
endmodule

// File: rtl/ctl_word_rx.sv
module ctl_word_rx
  import ctlrx_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int MIN_HIGH = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              en_n_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam logic [N_WIRES-1:0] SYNC_RST = N_WIRES'(1) << EN_IX;

  logic [N_WIRES-1:0] raw_w, sync_w;
  logic               en_rise, en_fall;
  logic [WORD_W-1:0]  shift_word;
  logic               bit_full;

  always_comb begin
    raw_w          = '0;
    raw_w[SCLK_IX] = sclk_i;
    raw_w[SDAT_IX] = sdata_i;
    raw_w[EN_IX]   = en_n_i;
  end

  ctlrx_sync #(.W(N_WIRES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_w),
    .q_o (sync_w)
  );

  ctlrx_edge #(.W(1), .RST_VAL(1'b1)) u_en_edge (
    .clk    (clk),
    .rst    (rst),
    .d_i    (sync_w[EN_IX]),
    .rise_o (en_rise),
    .fall_o (en_fall)
  );

  ctlrx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .act_i    (sel_i),
    .en_low_i (~sync_w[EN_IX]),
    .start_i  (en_fall),
    .sclk_s_i (sync_w[SCLK_IX]),
    .bit_i    (sync_w[SDAT_IX]),
    .word_o   (shift_word),
    .full_o   (bit_full)
  );

  ctlrx_commit #(.WORD_W(WORD_W), .MIN_HIGH(MIN_HIGH)) u_commit (
    .clk       (clk),
    .rst       (rst),
    .act_i     (sel_i),
    .en_hi_i   (sync_w[EN_IX]),
    .en_rise_i (en_rise),
    .full_i    (bit_full),
    .word_i    (shift_word),
    .word_o    (word_o),
    .vld_o     (word_vld_o)
  );

  AST_FULL_ONLY: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> bit_full); // R4
endmodule

// File: tb/ctl_word_rx_test.sv
module ctl_word_rx_test;
  localparam int MINH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b1;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic en_n = 1'b1;
  logic [7:0] word;
  logic vld;

  int checks = 0;
  int errors = 0;
  int vld_cnt = 0;
  logic prev_vld = 1'b0;

  always #5 clk = ~clk;

  ctl_word_rx #(.WORD_W(8), .MIN_HIGH(MINH)) uut (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (sel),
    .sclk_i     (sclk),
    .sdata_i    (sdata),
    .en_n_i     (en_n),
    .word_o     (word),
    .word_vld_o (vld)
  );

  // strobe monitor: counts pulses, flags strobes wider than one cycle (R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (vld) vld_cnt++;
      if (vld && prev_vld) begin
        errors++;
        $display("FAIL R6 strobe width actual >1 expected 1");
      end
    end
    prev_vld <= vld;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    summary();
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input int n, input logic [15:0] v);
    for (int i = 0; i < n; i++) begin
      sdata = v[15-i];
      cyc(4);
      sclk = 1'b1;
      cyc(4);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input int n, input logic [15:0] v, input int hi);
    en_n = 1'b0;
    cyc(4);
    send_bits(n, v);
    cyc(4);
    en_n = 1'b1;
    cyc(hi);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R8 word after reset", int'(word), 0);
    chk("R8 strobe after reset", int'(vld), 0);
  endtask

  task automatic t_basic(input logic [7:0] b);
    int c0 = vld_cnt;
    frame(8, {b, 8'h00}, 20);
    chk("R6 one strobe per frame", vld_cnt - c0, 1);
    chk("R2 word msb first", int'(word), int'(b));
  endtask

  task automatic t_short();
    int c0 = vld_cnt;
    logic [7:0] w0 = word;
    frame(5, 16'hF800, 20);
    chk("R4 short frame no strobe", vld_cnt - c0, 0);
    chk("R4 short frame word kept", int'(word), int'(w0));
  endtask

  task automatic t_long();
    int c0 = vld_cnt;
    frame(12, 16'h96F0, 20);
    chk("R5 long frame one strobe", vld_cnt - c0, 1);
    chk("R5 first eight kept", int'(word), 'h96);
  endtask

  task automatic t_sel_off();
    int c0 = vld_cnt;
    logic [7:0] w0 = word;
    sel = 1'b0;
    frame(8, 16'h5500, 20);
    chk("R1 deselected no strobe", vld_cnt - c0, 0);
    chk("R1 deselected word kept", int'(word), int'(w0));
    sel = 1'b1;
    cyc(4);
  endtask

  task automatic t_stray();
    int c0 = vld_cnt;
    logic [7:0] w0 = word;
    send_bits(8, 16'hFFFF);
    cyc(10);
    chk("R3 clocks while high no strobe", vld_cnt - c0, 0);
    chk("R3 clocks while high word kept", int'(word), int'(w0));
    frame(8, 16'h1200, 20);
    chk("R3 next frame exact", int'(word), 'h12);
  endtask

  task automatic t_gap_short();
    int c0 = vld_cnt;
    logic [7:0] w0 = word;
    frame(8, 16'hE700, MINH - 1);
    en_n = 1'b0;
    cyc(4);
    en_n = 1'b1;
    cyc(20);
    chk("R7 short high dropped", vld_cnt - c0, 0);
    chk("R7 word kept after drop", int'(word), int'(w0));
  endtask

  task automatic t_gap_exact();
    int c0 = vld_cnt;
    frame(8, 16'h6B00, MINH);
    en_n = 1'b0;
    cyc(4);
    en_n = 1'b1;
    cyc(20);
    chk("R6 exact min high commits", vld_cnt - c0, 1);
    chk("R6 exact min high word", int'(word), 'h6B);
  endtask

  task automatic t_b2b();
    int c0 = vld_cnt;
    frame(8, 16'h5A00, MINH);
    en_n = 1'b0;
    cyc(6);
    chk("R9 word held as next frame starts", int'(word), 'h5A);
    send_bits(8, 16'hC300);
    cyc(4);
    en_n = 1'b1;
    cyc(20);
    chk("R9 two strobes", vld_cnt - c0, 2);
    chk("R9 second word", int'(word), 'hC3);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    t_reset();
    t_basic(8'hA5);
    t_basic(8'h3C);
    t_basic(8'h80);
    t_short();
    t_long();
    t_sel_off();
    t_stray();
    t_gap_short();
    t_gap_exact();
    t_b2b();
    summary();
    $finish;
  end
endmodule